// File: doc/BRIEF.md
# Pre/post-trigger capture controller

This block is the acquisition core of an on-chip signal recorder. It writes channel samples into a circular buffer while it waits for a trigger. Once a trigger is accepted, it keeps recording for a programmed number of further samples and then stops. The stored window therefore holds the history that led up to the trigger as well as what followed it. The trigger decision is made elsewhere and arrives as a single input. The block only judges whether that input may be honoured yet.

Samples are taken in one of two ways. In timing mode a divider paced by the internal clock produces a sample every `cfg_div+1` cycles. In state mode a sample is taken on a chosen edge of a clock from the circuit under test, and an optional qualifier input can suppress that sample. The target clock, the qualifier and the channels are all brought into the internal clock domain through two register stages before use. After a capture completes, a random-access read port returns the window oldest-first, and `trig_index` reports where the trigger sample sits in it. Acknowledging the capture either returns the block to idle or, in repeat mode, starts the next capture straight away.

Top module: `twc_capture`

## Requirements
- R1: After reset `status` is 0 (idle) and `trig_index` is 0, and the block stays idle until `arm` is seen.
- R2: In timing mode (`cfg_state_mode`=0) a sample is stored every `cfg_div+1` clock cycles while capturing. The first sample is stored on the `cfg_div+1`-th rising clock edge after the edge that starts the capture.
- R3: In state mode (`cfg_state_mode`=1) a sample is taken when the synchronized target clock rises (`cfg_edge_fall`=0) or falls (`cfg_edge_fall`=1). The stored value is the channel input that was stable at that target edge.
- R4: With `cfg_qual_en`=1, a state-mode edge is stored only if the synchronized `tgt_qual` equals `cfg_qual_level`. Otherwise the edge is dropped.
- R5: With pre-trigger length P = 256 - post, `trig` is ignored until P samples have been stored since the capture started. `status` is 1 while this pre-fill runs and 2 while the block waits for a trigger.
- R6: An accepted trigger (`trig` high on a sample) counts as the first of `post` post-trigger samples. `status` is 3 until the last of them is stored and then 4 (complete). When post=0, the trigger sample itself is not stored and `status` goes straight to 4.
- R7: In the complete state, `rd_data` returns the entry at offset `rd_addr` from the oldest stored sample, one clock after `rd_addr` is applied. `trig_index` equals 256 - post, and is 256 when post=0.
- R8: In single-shot mode (`cfg_repeat`=0, latched at capture start), a `done_ack` pulse in the complete state returns `status` to 0, where it stays until the next `arm`.
- R9: In repeat mode, a `done_ack` pulse in the complete state immediately starts a new capture (`status` 1, or 2 when post=256).
- R10: `done_ack` has no effect outside the complete state, and `arm` has no effect outside the idle state.
- R11: A `cfg_post` value above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_state_mode | input | 1 | 0 timing mode, 1 state mode |
| cfg_div | input | DIV_W | Timing-mode interval minus one |
| cfg_edge_fall | input | 1 | State mode: 0 rising, 1 falling target edge |
| cfg_qual_en | input | 1 | Enable state-mode qualifier |
| cfg_qual_level | input | 1 | Qualifier level that allows a sample |
| cfg_post | input | AW+1 | Post-trigger sample count, clamped to 256 |
| cfg_repeat | input | 1 | 1 re-arms after acknowledge |
| arm | input | 1 | Start a capture from idle |
| done_ack | input | 1 | Acknowledge a completed capture |
| trig | input | 1 | Trigger condition from the trigger logic |
| tgt_clk | input | 1 | Asynchronous clock of the circuit under test |
| tgt_qual | input | 1 | Asynchronous qualifier input |
| chan_in | input | CH_W | Channel inputs |
| rd_addr | input | AW | Readout offset from the oldest sample |
| rd_data | output | CH_W | Readout data, one cycle latency |
| status | output | 3 | 0 idle, 1 pre-fill, 2 wait trigger, 3 post-fill, 4 complete |
| trig_index | output | AW+1 | Oldest-first index of the trigger sample |

## Verification
A write pointer that slips shows up on readout as two adjacent entries whose recorded counter values differ by something other than the sample interval. The bench sees this as soon as the window is read back after completion. A fill or post counter that is off by one moves the cycle in which `status` reaches 4, so the bench checks that edge exactly, one cycle before and on the cycle itself. A bad synchronizer or edge selector records the wrong stimulus values, and a bad qualifier lets odd-numbered values through. Both are exposed entry by entry in the state-mode windows. A wrong mode flag or a latched repeat bit is visible in `status` on the cycle after `done_ack`.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } cap_state_t;
endpackage

// File: rtl/twc_strobe.sv
module twc_strobe #(
  parameter int CH_W  = 8,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              state_mode,
  input  logic              edge_fall,
  input  logic              qual_en,
  input  logic              qual_level,
  input  logic [DIV_W-1:0]  div,
  input  logic              tgt_clk,
  input  logic              tgt_qual,
  input  logic [CH_W-1:0]   chan_in,
  output logic              stb,
  output logic [CH_W-1:0]   sample
);
  // two-stage synchronizers, third stage on the clock for edge finding
  logic [2:0]       ck_sr;
  logic [1:0]       q_sr;
  logic [CH_W-1:0]  d1, d2;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sr <= '0;
      q_sr  <= '0;
      d1    <= '0;
      d2    <= '0;
    end else begin
      ck_sr <= {ck_sr[1:0], tgt_clk};
      q_sr  <= {q_sr[0], tgt_qual};
      d1    <= chan_in;
      d2    <= d1;
    end
  end

  // interval divider, cleared whenever no capture runs
  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  logic rose, fell, edge_hit, qual_ok;
  always_comb begin
    rose     = ck_sr[1] & ~ck_sr[2];
    fell     = ~ck_sr[1] & ck_sr[2];
    edge_hit = edge_fall ? fell : rose;
    qual_ok  = !qual_en || (q_sr[1] == qual_level);
    stb      = run && (state_mode ? (edge_hit && qual_ok) : (cnt == div));
    sample   = d2;
  end

  // R3: a synchronized target edge cannot repeat on the next cycle
  assert_state_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (state_mode && stb) |=> !stb);
  // R2: with an interval above one cycle, strobes are never adjacent
  assert_timing_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (!state_mode && run && div != '0 && stb) |=> !stb);
endmodule

// File: rtl/twc_ram.sv
module twc_ram #(
  parameter int CH_W = 8,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CH_W-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [CH_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twc_ctrl.sv
module twc_ctrl
  import twc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          done_ack,
  input  logic          trig,
  input  logic          stb,
  input  logic [AW:0]   post_cfg,
  input  logic          repeat_cfg,
  output cap_state_t    st,
  output logic          run,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] base,
  output logic [AW:0]   trig_idx
);
  localparam logic [AW:0]   DEPTH_C = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   ONE_C   = {{AW{1'b0}}, 1'b1};
  localparam logic [AW-1:0] ONE_A   = {{(AW-1){1'b0}}, 1'b1};

  logic [AW:0]   post_l, post_left, fill_cnt, post_clamp, pre_n;
  logic [AW-1:0] wp;
  logic          rep_l, start;

  always_comb begin
    post_clamp = (post_cfg > DEPTH_C) ? DEPTH_C : post_cfg;
    pre_n      = DEPTH_C - post_l;
    start      = (st == ST_IDLE && arm) || (st == ST_DONE && done_ack && rep_l);
    run        = (st == ST_PRE) || (st == ST_WAIT) || (st == ST_POST);
    we         = stb && ((st == ST_PRE) || (st == ST_POST) ||
                         (st == ST_WAIT && !(trig && post_l == '0)));
    waddr      = wp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wp        <= '0;
      base      <= '0;
      trig_idx  <= '0;
      post_l    <= '0;
      post_left <= '0;
      fill_cnt  <= '0;
      rep_l     <= 1'b0;
    end else if (start) begin
      post_l   <= post_clamp;
      fill_cnt <= '0;
      rep_l    <= repeat_cfg;
      st       <= (post_clamp == DEPTH_C) ? ST_WAIT : ST_PRE;
    end else begin
      case (st)
        ST_PRE: if (stb) begin
          wp       <= wp + ONE_A;
          fill_cnt <= fill_cnt + ONE_C;
          if (fill_cnt + ONE_C == pre_n) st <= ST_WAIT;
        end
        ST_WAIT: if (stb) begin
          if (trig) begin
            trig_idx <= DEPTH_C - post_l;
            if (post_l == '0) begin
              st   <= ST_DONE;
              base <= wp;
            end else begin
              wp        <= wp + ONE_A;
              post_left <= post_l - ONE_C;
              if (post_l == ONE_C) begin
                st   <= ST_DONE;
                base <= wp + ONE_A;
              end else begin
                st <= ST_POST;
              end
            end
          end else begin
            wp <= wp + ONE_A;
          end
        end
        ST_POST: if (stb) begin
          wp        <= wp + ONE_A;
          post_left <= post_left - ONE_C;
          if (post_left == ONE_C) begin
            st   <= ST_DONE;
            base <= wp + ONE_A;
          end
        end
        ST_DONE: if (done_ack && !rep_l) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: each stored sample advances the ring pointer by exactly one
  assert_wp_step_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> waddr == $past(waddr) + ONE_A);
  // R5: pre-fill can only continue or hand over to trigger wait
  assert_prefill_no_trig_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PRE) |=> (st == ST_PRE || st == ST_WAIT));
  // R6: post-fill always has samples left to take
  assert_post_left_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POST) |-> post_left != '0);
  // R10: complete state is held until acknowledged
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && !done_ack) |=> st == ST_DONE);
  // R1: idle is held until armed
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !arm) |=> st == ST_IDLE);
endmodule

// File: rtl/twc_capture.sv
module twc_capture
  import twc_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int AW    = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_state_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_edge_fall,
  input  logic             cfg_qual_en,
  input  logic             cfg_qual_level,
  input  logic [AW:0]      cfg_post,
  input  logic             cfg_repeat,
  input  logic             arm,
  input  logic             done_ack,
  input  logic             trig,
  input  logic             tgt_clk,
  input  logic             tgt_qual,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [AW-1:0]    rd_addr,
  output logic [CH_W-1:0]  rd_data,
  output logic [2:0]       status,
  output logic [AW:0]      trig_index
);
  cap_state_t      st;
  logic            run, stb, we;
  logic [CH_W-1:0] sample;
  logic [AW-1:0]   waddr, base, raddr;

  twc_strobe #(.CH_W(CH_W), .DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst(rst), .run(run), .state_mode(cfg_state_mode),
    .edge_fall(cfg_edge_fall), .qual_en(cfg_qual_en), .qual_level(cfg_qual_level),
    .div(cfg_div), .tgt_clk(tgt_clk), .tgt_qual(tgt_qual), .chan_in(chan_in),
    .stb(stb), .sample(sample)
  );

  twc_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .done_ack(done_ack), .trig(trig), .stb(stb),
    .post_cfg(cfg_post), .repeat_cfg(cfg_repeat), .st(st), .run(run), .we(we),
    .waddr(waddr), .base(base), .trig_idx(trig_index)
  );

  assign raddr  = base + rd_addr;
  assign status = st;

  twc_ram #(.CH_W(CH_W), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(sample),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/twc_capture_test.sv
module twc_capture_test;
  localparam int CH_W = 16;
  localparam int AW = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_state_mode = 1'b0, cfg_edge_fall = 1'b0, cfg_qual_en = 1'b0;
  logic cfg_qual_level = 1'b0, cfg_repeat = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [AW:0] cfg_post = '0;
  logic arm = 1'b0, done_ack = 1'b0, trig = 1'b0;
  logic tgt_clk = 1'b0, tgt_qual = 1'b0;
  logic [CH_W-1:0] chan_in, man_chan = '0, cyc = '0;
  logic use_cyc = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [CH_W-1:0] rd_data;
  logic [2:0] status;
  logic [AW:0] trig_index;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;
  assign chan_in = use_cyc ? cyc : man_chan;

  twc_capture #(.CH_W(CH_W), .AW(AW), .DIV_W(16)) uut (
    .clk(clk), .rst(rst), .cfg_state_mode(cfg_state_mode), .cfg_div(cfg_div),
    .cfg_edge_fall(cfg_edge_fall), .cfg_qual_en(cfg_qual_en),
    .cfg_qual_level(cfg_qual_level), .cfg_post(cfg_post), .cfg_repeat(cfg_repeat),
    .arm(arm), .done_ack(done_ack), .trig(trig), .tgt_clk(tgt_clk),
    .tgt_qual(tgt_qual), .chan_in(chan_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .status(status), .trig_index(trig_index)
  );

  // stimulus table: {post count, interval minus one}
  localparam logic [31:0] VEC [5] = '{
    {16'd100, 16'd0}, {16'd256, 16'd2}, {16'd0, 16'd1},
    {16'd1, 16'd0},   {16'd300, 16'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) done_ack = 1'b1;
    @(negedge clk) done_ack = 1'b0;
  endtask

  task automatic read_entry(input int idx, output logic [CH_W-1:0] val);
    @(negedge clk) rd_addr = idx[AW-1:0];
    @(negedge clk) val = rd_data;
  endtask

  task automatic tgt_cycle(input logic rise_first, input logic [CH_W-1:0] v,
                           input logic q);
    @(negedge clk);
    man_chan = v;
    tgt_qual = q;
    tgt_clk  = rise_first ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    tgt_clk = rise_first ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [CH_W-1:0] prev, cur;
    int bad;
    // R1 reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 3'd0, "R1 idle after reset", status, 0);
    chk(trig_index == '0, "R1 trig_index after reset", trig_index, 0);
    repeat (5) @(negedge clk);
    chk(status == 3'd0, "R1 stays idle without arm", status, 0);

    // table walk in timing mode with trigger held high
    for (int v = 0; v < 5; v++) begin
      int post, dv, eff, n_exp;
      post = VEC[v][31:16];
      dv = VEC[v][15:0];
      eff = (post > DEPTH) ? DEPTH : post;
      n_exp = (eff == 0) ? (DEPTH + 1) * (dv + 1) : DEPTH * (dv + 1);
      cfg_state_mode = 1'b0;
      cfg_div = dv[15:0];
      cfg_post = post[AW:0];
      cfg_repeat = 1'b0;
      use_cyc = 1'b1;
      trig = 1'b1;
      pulse_arm();
      repeat (n_exp - 1) @(negedge clk);
      chk(status != 3'd4, "R2 R6 not complete one cycle early", status, 4);
      @(negedge clk);
      chk(status == 3'd4, "R2 R6 complete at expected cycle", status, 4);
      chk(trig_index == (DEPTH - eff), "R7 R11 trig_index", trig_index, DEPTH - eff);
      bad = 0;
      read_entry(0, prev);
      for (int j = 1; j < DEPTH; j++) begin
        read_entry(j, cur);
        if (cur - prev != CH_W'(dv + 1) && bad == 0) begin
          bad = 1;
          chk(1'b0, "R2 R7 sample spacing", cur - prev, dv + 1);
        end
        prev = cur;
      end
      if (bad == 0) chk(1'b1, "R2 R7 sample spacing", 0, 0);
      trig = 1'b0;
      pulse_ack();
      chk(status == 3'd0, "R8 single-shot returns idle", status, 0);
    end
    repeat (6) @(negedge clk);
    chk(status == 3'd0, "R8 idle holds after single shot", status, 0);

    // R5 / R6 / R10: pre-fill ignores trigger, post count exact
    cfg_div = 16'd0;
    cfg_post = 9'd128;
    pulse_arm();
    repeat (10) @(negedge clk);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(status == 3'd1, "R5 trigger ignored in pre-fill", status, 1);
    pulse_ack();
    chk(status == 3'd1, "R10 done_ack ignored in pre-fill", status, 1);
    pulse_arm();
    chk(status == 3'd1, "R10 arm ignored while capturing", status, 1);
    for (int k = 0; k < 300 && status != 3'd2; k++) @(negedge clk);
    chk(status == 3'd2, "R5 waits for trigger after pre-fill", status, 2);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(status == 3'd3, "R6 post-fill after trigger", status, 3);
    repeat (126) @(negedge clk);
    chk(status == 3'd3, "R6 still post-fill before last sample", status, 3);
    @(negedge clk);
    chk(status == 3'd4, "R6 complete after post samples", status, 4);
    chk(trig_index == 9'd128, "R7 trig_index for post 128", trig_index, 128);
    pulse_ack();

    // R3 state mode, rising edge
    use_cyc = 1'b0;
    cfg_state_mode = 1'b1;
    cfg_edge_fall = 1'b0;
    cfg_qual_en = 1'b0;
    cfg_post = 9'd256;
    tgt_clk = 1'b0;
    trig = 1'b1;
    repeat (4) @(negedge clk);
    pulse_arm();
    for (int i = 0; i < DEPTH; i++) tgt_cycle(1'b1, CH_W'(16'h1000 + i), 1'b0);
    tgt_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk(status == 3'd4, "R3 rising-edge capture complete", status, 4);
    bad = 0;
    for (int j = 0; j < DEPTH; j++) begin
      read_entry(j, cur);
      if (cur != CH_W'(16'h1000 + j) && bad == 0) begin
        bad = 1;
        chk(1'b0, "R3 rising-edge values", cur, 16'h1000 + j);
      end
    end
    if (bad == 0) chk(1'b1, "R3 rising-edge values", 0, 0);
    pulse_ack();

    // R3 falling edge + R4 qualifier + R9 repeat
    cfg_edge_fall = 1'b1;
    cfg_qual_en = 1'b1;
    cfg_qual_level = 1'b0;
    cfg_repeat = 1'b1;
    tgt_clk = 1'b1;
    repeat (4) @(negedge clk);
    pulse_arm();
    for (int i = 0; i < 2 * DEPTH; i++)
      tgt_cycle(1'b0, CH_W'(16'h2000 + i), i[0]);
    tgt_clk = 1'b1;
    repeat (6) @(negedge clk);
    chk(status == 3'd4, "R4 qualified capture complete", status, 4);
    bad = 0;
    for (int j = 0; j < DEPTH; j++) begin
      read_entry(j, cur);
      if (cur != CH_W'(16'h2000 + 2 * j) && bad == 0) begin
        bad = 1;
        chk(1'b0, "R3 R4 falling-edge qualified values", cur, 16'h2000 + 2 * j);
      end
    end
    if (bad == 0) chk(1'b1, "R3 R4 falling-edge qualified values", 0, 0);
    pulse_ack();
    chk(status == 3'd2, "R9 repeat restarts capture", status, 2);

    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(status == 3'd0, "R1 idle after second reset", status, 0);
    finish_up();
  end
endmodule